// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns parallel words into an asynchronous serial stream. A word written to the block is framed with a low start bit, then an 8- or 9-bit field sent least significant bit first, then a high stop period. The ninth bit is either a raw data bit or a parity bit, computed at write time. A one-word holding buffer sits in front of the shift register, so software can queue the next word while the current frame is still leaving the line.

Timing comes from a one-cycle sample tick at sixteen times the bit rate. An internal divide-by-16 counter turns the ticks into bit boundaries. Every frame starts on a counter overflow, and every start and data bit lasts exactly 16 ticks. The stop period is counted in ticks, so half-bit and one-and-a-half-bit stop lengths are exact. Two flags report progress. The buffer-empty flag is high when the holding buffer has room. The transmitter-empty flag rises as soon as the last data bit has gone out.

Top module: `ser_tx_dbuf`

## Requirements
- R1: While reset is asserted, and after it is released, `txd` is 1 and both `buf_empty` and `tx_empty` are 1.
- R2: A frame's start bit (`txd` = 0) begins only in the cycle after a sample tick on which the divide-by-16 counter overflows. The counter overflows on the 16th tick counted while `run_en` is 1. The start bit lasts 16 ticks. With no sample ticks, a loaded word never starts.
- R3: A write accepted while the transmitter holds no word goes straight to the shift register. `buf_empty` stays 1 and `tx_empty` is 0 from the next cycle.
- R4: A write accepted while a word occupies the shift register goes to the holding buffer, and `buf_empty` is 0 from the next cycle. A further write while the buffer is full replaces the buffered word.
- R5: The field is sent least significant bit first, 16 ticks per bit. It is 8 bits when `wide_sel` = 0 and 9 bits when `wide_sel` = 1.
- R6: With `wide_sel` = 1 and `par_en` = 1, the ninth bit is a parity bit. When `par_odd` = 0 it is the XOR of the 8 data bits (even parity). When `par_odd` = 1 it is the inverse of that XOR (odd parity). With `par_en` = 0, the ninth bit is `wr_data[8]`.
- R7: `stop_sel` sets how long the line stays high after the data: 0 gives 8 ticks, 1 gives 16, 2 gives 24 and 3 gives 32.
- R8: `tx_empty` rises in the first clock cycle of the stop period, which is the cycle after the overflow that ends the last data bit.
- R9: When the stop period ends, a buffered word moves into the shift register and `buf_empty` returns to 1 in the next cycle. The new frame starts at once if that last stop tick is also an overflow; otherwise it starts at the next overflow.
- R10: While `run_en` is 0, the frame in progress and any buffered word are dropped, and the divide-by-16 counter is cleared. From the next cycle on, `txd`, `buf_empty` and `tx_empty` are all 1. Writes made while `run_en` is 0 are ignored.
- R11: The field width, parity mode and stop length are captured with each write. Changing the select inputs later does not alter a word that has already been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| run_en | input | 1 | Enables the block; 0 aborts and clears it |
| wide_sel | input | 1 | 1 selects a 9-bit field, 0 an 8-bit field |
| par_en | input | 1 | Ninth bit is parity when 1 |
| par_odd | input | 1 | 1 selects odd parity, 0 even parity |
| stop_sel | input | 2 | Stop length code: 0=8, 1=16, 2=24, 3=32 ticks |
| wr_stb | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 9 | Word to send; bit 8 is used only as a raw ninth bit |
| txd | output | 1 | Serial line, high when idle |
| buf_empty | output | 1 | Holding buffer has room |
| tx_empty | output | 1 | No data bits remain to be shifted |

## Verification
The bench stops the sample ticks right after loading a word. A design that started frames without waiting for a counter overflow would pull the line low during that pause. It overwrites a full buffer, queues words back to back across all four stop lengths, and switches between sparse and dense ticks. A design that restarted too late after a half-bit stop, dropped the buffered word at the end of a stop, or raised `tx_empty` one bit late would drift from the cycle-level reference model. Aborting mid-frame and writing while disabled catches designs that keep buffered data or leave the line low. Changing the selects after a write exposes designs that read the width, parity or stop inputs live instead of capturing them with the word.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_START,
    ST_DATA,
    ST_STOP
  } tx_state_e;

  // Stop period in sample ticks: (code + 1) half bits.
  function automatic logic [31:0] stop_ticks(input logic [1:0] code,
                                             input int unsigned div_w);
    return (32'(code) + 32'd1) << (div_w - 1);
  endfunction

endpackage

// File: rtl/ser_tx_baud_div.sv
module ser_tx_baud_div #(
  parameter int unsigned DIV_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic samp_tick,
  output logic tick_en,
  output logic bit_ovf
);

  logic [DIV_W-1:0] div_q, div_d;

  always_comb begin
    div_d = div_q;
    if (!run)           div_d = '0;
    else if (samp_tick) div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_en = run & samp_tick;
  assign bit_ovf = tick_en & (&div_q);

  AST_DIV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (div_q == '0));  // R10

endmodule

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int unsigned FW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load,
  input  logic          take,
  input  logic [FW-1:0] in_field,
  input  logic          in_wide,
  input  logic [1:0]    in_stop,
  output logic          vld,
  output logic [FW-1:0] field,
  output logic          wide,
  output logic [1:0]    stop
);

  logic vld_q, vld_d;
  logic [FW-1:0] field_q;
  logic wide_q;
  logic [1:0] stop_q;

  always_comb begin
    vld_d = vld_q;
    if (!run)      vld_d = 1'b0;
    else if (load) vld_d = 1'b1;
    else if (take) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // Payload registers, enabled only by an accepted write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
      wide_q  <= 1'b0;
      stop_q  <= 2'd0;
    end else if (load) begin
      field_q <= in_field;
      wide_q  <= in_wide;
      stop_q  <= in_stop;
    end
  end

  assign vld   = vld_q;
  assign field = field_q;
  assign wide  = wide_q;
  assign stop  = stop_q;

  AST_HOLD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && load) |=> vld_q);  // R4

endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter
  import ser_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 4,
  parameter int unsigned FW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick_en,
  input  logic          bit_ovf,
  input  logic          load,
  input  logic [FW-1:0] ld_field,
  input  logic          ld_wide,
  input  logic [1:0]    ld_stop,
  output logic          free,
  output logic          sh_idle,
  output logic          txd,
  output logic          tx_empty
);

  localparam int unsigned IDX_W = $clog2(FW);
  localparam int unsigned SCW   = DIV_W + 2;

  tx_state_e      state_q, state_d;
  logic [FW-1:0]  shreg_q, shreg_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic           wide_q, wide_d;
  logic [1:0]     stop_q, stop_d;
  logic [SCW-1:0] scnt_q, scnt_d;

  logic [IDX_W-1:0] last_idx;
  logic [SCW-1:0]   stop_len;
  logic             stop_done;

  assign last_idx  = wide_q ? IDX_W'(FW - 1) : IDX_W'(FW - 2);
  assign stop_len  = SCW'(stop_ticks(stop_q, DIV_W));
  assign stop_done = (state_q == ST_STOP) & tick_en & (scnt_q == stop_len - SCW'(1));
  assign free      = (state_q == ST_IDLE) | stop_done;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    idx_d   = idx_q;
    wide_d  = wide_q;
    stop_d  = stop_q;
    scnt_d  = scnt_q;
    if (!run) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_WAIT:  if (bit_ovf) state_d = ST_START;
        ST_START: if (bit_ovf) begin
                    state_d = ST_DATA;
                    idx_d   = '0;
                  end
        ST_DATA:  if (bit_ovf) begin
                    if (idx_q == last_idx) begin
                      state_d = ST_STOP;
                      scnt_d  = '0;
                    end else begin
                      shreg_d = shreg_q >> 1;
                      idx_d   = idx_q + IDX_W'(1);
                    end
                  end
        ST_STOP:  if (tick_en) begin
                    if (stop_done) state_d = ST_IDLE;
                    else           scnt_d  = scnt_q + SCW'(1);
                  end
        default:  state_d = ST_IDLE;
      endcase
      if (load) begin
        state_d = bit_ovf ? ST_START : ST_WAIT;
        shreg_d = ld_field;
        wide_d  = ld_wide;
        stop_d  = ld_stop;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      idx_q   <= '0;
      wide_q  <= 1'b0;
      stop_q  <= 2'd0;
      scnt_q  <= '0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      idx_q   <= idx_d;
      wide_q  <= wide_d;
      stop_q  <= stop_d;
      scnt_q  <= scnt_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = shreg_q[0];
      default:  txd = 1'b1;
    endcase
  end

  assign tx_empty = (state_q == ST_IDLE) | (state_q == ST_STOP);
  assign sh_idle  = (state_q == ST_IDLE);

  AST_START_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && $past(state_q) != ST_START) |-> $past(bit_ovf));  // R2
  AST_DATA_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (idx_q <= last_idx));  // R5
  AST_STOP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> (scnt_q < stop_len));  // R7
  AST_TXE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !$past(tx_empty)) |-> ($past(bit_ovf) || !$past(run)));  // R8

endmodule

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf
  import ser_tx_pkg::*;
#(
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_tick,
  input  logic              run_en,
  input  logic              wide_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic [1:0]        stop_sel,
  input  logic              wr_stb,
  input  logic [DATA_W:0]   wr_data,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_empty
);

  localparam int unsigned FW = DATA_W + 1;

  logic tick_en, bit_ovf;
  logic free, sh_idle;
  logic ninth;
  logic [FW-1:0] wr_field;
  logic wr_go, hold_load, hold_take, sh_load;
  logic hold_vld, hold_wide;
  logic [FW-1:0] hold_field;
  logic [1:0] hold_stop;
  logic [FW-1:0] src_field;
  logic src_wide;
  logic [1:0] src_stop;

  ser_tx_baud_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_en),
    .samp_tick (samp_tick),
    .tick_en   (tick_en),
    .bit_ovf   (bit_ovf)
  );

  // Ninth bit resolved at write time so later select changes have no effect.
  always_comb begin
    if (!wide_sel)   ninth = 1'b0;
    else if (par_en) ninth = (^wr_data[DATA_W-1:0]) ^ par_odd;
    else             ninth = wr_data[DATA_W];
  end
  assign wr_field = {ninth, wr_data[DATA_W-1:0]};

  assign wr_go     = run_en & wr_stb;
  assign hold_load = wr_go & (~free | hold_vld);
  assign hold_take = run_en & free & hold_vld;
  assign sh_load   = run_en & free & (hold_vld | wr_stb);

  ser_tx_hold #(.FW(FW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_en),
    .load     (hold_load),
    .take     (hold_take),
    .in_field (wr_field),
    .in_wide  (wide_sel),
    .in_stop  (stop_sel),
    .vld      (hold_vld),
    .field    (hold_field),
    .wide     (hold_wide),
    .stop     (hold_stop)
  );

  assign src_field = hold_vld ? hold_field : wr_field;
  assign src_wide  = hold_vld ? hold_wide  : wide_sel;
  assign src_stop  = hold_vld ? hold_stop  : stop_sel;

  ser_tx_shifter #(.DIV_W(DIV_W), .FW(FW)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_en),
    .tick_en  (tick_en),
    .bit_ovf  (bit_ovf),
    .load     (sh_load),
    .ld_field (src_field),
    .ld_wide  (src_wide),
    .ld_stop  (src_stop),
    .free     (free),
    .sh_idle  (sh_idle),
    .txd      (txd),
    .tx_empty (tx_empty)
  );

  assign buf_empty = ~hold_vld;

  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (txd && buf_empty && tx_empty));  // R10
  AST_NO_STRANDED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    sh_idle |-> !hold_vld);  // R9
  AST_IDLE_WRITE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_idle && wr_go) |=> (!sh_idle && !hold_vld));  // R3

endmodule

// File: tb/ser_tx_dbuf_tb.sv
`timescale 1ns/1ps
module ser_tx_dbuf_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, samp_tick, run_en, wide_sel, par_en, par_odd, wr_stb;
  logic [1:0] stop_sel;
  logic [8:0] wr_data;
  logic txd, buf_empty, tx_empty;

  ser_tx_dbuf u_dut (
    .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .run_en(run_en),
    .wide_sel(wide_sel), .par_en(par_en), .par_odd(par_odd),
    .stop_sel(stop_sel), .wr_stb(wr_stb), .wr_data(wr_data),
    .txd(txd), .buf_empty(buf_empty), .tx_empty(tx_empty)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  bit started = 0;

  // Sample tick generator: one pulse every tick_per cycles, none when 0.
  int tick_per = 0;
  int tick_ctr = 0;
  always @(negedge clk) begin
    if (tick_per == 0) begin
      samp_tick = 1'b0;
      tick_ctr  = 0;
    end else begin
      samp_tick = (tick_ctr == 0);
      tick_ctr  = (tick_ctr + 1) % tick_per;
    end
  end

  // Behavioural reference model: tick position inside the frame.
  bit m_send, m_load;
  int m_pos, m_field, m_nb, m_stop, m_div;
  int m_hold[$];

  function automatic int make_entry();
    int d, nb, n9, st;
    d  = int'(wr_data[7:0]);
    nb = wide_sel ? 9 : 8;
    n9 = 0;
    if (wide_sel) n9 = par_en ? (($countones(wr_data[7:0]) % 2) ^ int'(par_odd)) : int'(wr_data[8]);
    st = (int'(stop_sel) + 1) * 8;
    return d | (n9 << 8) | (nb << 10) | (st << 16);
  endfunction

  function automatic int flen();
    return 16 * (1 + m_nb) + m_stop;
  endfunction

  task automatic take_entry(input int e, input bit ovf);
    m_field = e & 16'h1ff;
    m_nb    = (e >> 10) & 16'h3f;
    m_stop  = (e >> 16) & 16'hff;
    if (ovf) begin m_send = 1; m_load = 0; m_pos = 0; end
    else     begin m_send = 0; m_load = 1; end
  endtask

  always @(posedge clk) begin
    if (!rst_n || !run_en) begin
      m_send = 0; m_load = 0; m_pos = 0; m_div = 0;
      m_hold.delete();
    end else begin
      bit ovf, done_f, free_f, tk;
      int nf;
      tk  = samp_tick;
      ovf = tk && (m_div == 15);
      if (tk) m_div = (m_div + 1) % 16;
      done_f = m_send && tk && (m_pos + 1 == flen());
      free_f = (!m_send && !m_load) || done_f;
      nf = make_entry();
      if (free_f) begin
        if (m_hold.size() > 0) begin
          take_entry(m_hold.pop_front(), ovf);
          if (wr_stb) m_hold.push_back(nf);
        end else if (wr_stb) begin
          take_entry(nf, ovf);
        end else begin
          m_send = 0; m_load = 0;
        end
      end else begin
        if (wr_stb) begin m_hold.delete(); m_hold.push_back(nf); end
        if (m_send && tk) m_pos++;
        else if (m_load && ovf) begin m_send = 1; m_load = 0; m_pos = 0; end
      end
    end
    started = 1;
  end

  function automatic logic exp_txd();
    if (!m_send) return 1'b1;
    if (m_pos < 16) return 1'b0;
    if (m_pos < 16 * (1 + m_nb)) return logic'((m_field >> (m_pos / 16 - 1)) & 1);
    return 1'b1;
  endfunction

  function automatic logic exp_txe();
    return !m_load && (!m_send || m_pos >= 16 * (1 + m_nb));
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (started && !done) begin
      chk("txd line (R2 R5 R6 R7 R9 R11)", txd, exp_txd());
      chk("tx_empty (R8)", tx_empty, exp_txe());
      chk("buf_empty (R4 R9)", buf_empty, logic'(m_hold.size() == 0));
    end
  end

  task automatic write_word(input logic [8:0] d, input logic w, input logic pe,
                            input logic po, input logic [1:0] ss);
    wr_data = d; wide_sel = w; par_en = pe; par_odd = po; stop_sel = ss;
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_quiet(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (!m_send && !m_load && m_hold.size() == 0) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_room(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (buf_empty) break;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog (R1 R2) actual=running expected=finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; wr_stb = 1'b0; wr_data = '0;
    wide_sel = 1'b0; par_en = 1'b0; par_odd = 1'b0; stop_sel = 2'd0;
    repeat (4) @(negedge clk);
    chk("R1 txd in reset", txd, 1'b1);
    chk("R1 buf_empty in reset", buf_empty, 1'b1);
    chk("R1 tx_empty in reset", tx_empty, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd after reset", txd, 1'b1);
    run_en = 1'b1;
    @(negedge clk);

    // R3 idle write bypasses the buffer; R2 nothing starts without ticks.
    tick_per = 0;
    write_word(9'h0A5, 1'b0, 1'b0, 1'b0, 2'd1);
    chk("R3 buf_empty after idle write", buf_empty, 1'b1);
    chk("R3 tx_empty after idle write", tx_empty, 1'b0);
    for (int i = 0; i < 60; i++) begin
      chk("R2 line held high without overflow", txd, 1'b1);
      @(negedge clk);
    end
    tick_per = 3;

    // R4 buffered write and overwrite; R11 selects changed afterwards.
    repeat (100) @(negedge clk);
    write_word(9'h03C, 1'b1, 1'b1, 1'b0, 2'd2);
    chk("R4 buf_empty after busy write", buf_empty, 1'b0);
    write_word(9'h00F, 1'b1, 1'b1, 1'b1, 2'd0);
    chk("R4 buf_empty after overwrite", buf_empty, 1'b0);
    wide_sel = 1'b0; par_en = 1'b0; stop_sel = 2'd3;
    wait_quiet(5000);

    // Back-to-back frames over all modes and stop lengths (R5 R6 R7 R9).
    for (int i = 0; i < 12; i++) begin
      if (i == 6) tick_per = 1;
      wait_room(5000);
      write_word(9'((i * 149 + 77) & 511), logic'(i % 2), logic'((i / 2) % 2),
                 logic'((i / 4) % 2), 2'(i % 4));
    end
    wait_quiet(8000);
    chk("R9 buffer drained", buf_empty, 1'b1);
    chk("R8 transmitter empty at end", tx_empty, 1'b1);

    // R10 abort mid-frame, writes ignored while disabled.
    tick_per = 2;
    write_word(9'h155, 1'b1, 1'b0, 1'b0, 2'd3);
    write_word(9'h0AA, 1'b0, 1'b0, 1'b0, 2'd1);
    repeat (70) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    chk("R10 txd after abort", txd, 1'b1);
    chk("R10 buf_empty after abort", buf_empty, 1'b1);
    chk("R10 tx_empty after abort", tx_empty, 1'b1);
    write_word(9'h000, 1'b0, 1'b0, 1'b0, 2'd0);
    run_en = 1'b1;
    @(negedge clk);
    chk("R10 write while disabled ignored (buf)", buf_empty, 1'b1);
    chk("R10 write while disabled ignored (txe)", tx_empty, 1'b1);
    for (int i = 0; i < 100; i++) begin
      chk("R10 line stays high after ignored write", txd, 1'b1);
      @(negedge clk);
    end

    // Final frame after re-enable, odd parity, half stop.
    write_word(9'h081, 1'b1, 1'b1, 1'b1, 2'd0);
    wait_quiet(5000);
    repeat (10) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end

endmodule